// File: doc/BRIEF.md
# De-ramping Beat-Signal Decimator

This block is the front end of linear-FM de-ramp range processing. On every accepted cycle it multiplies a received sample by the reference chirp sample for the same index. The result is a beat-frequency signal. That signal passes through a triangular-weighted low-pass FIR and is then decimated by an integer factor. The output is a frame of a fixed number of decimated beat samples for each sweep, ready for a downstream FFT. The final sample of each frame is flagged.

A sweep trigger opens a new frame. It clears the filter history and restarts the sample and output counters. Once a frame is complete, the block stays silent until the next trigger. The filter length, the decimation factor and the frame length are parameters. The reference setting is 512 taps, decimation by 22 and 16384 outputs per frame. The filter stop band should sit at the highest beat frequency of interest. The decimation factor should not exceed the sample rate divided by twice that frequency. The output band then spans zero up to the sample rate divided by twice the factor.

Top module: `deramp_decim`

## Requirements
- R1: After reset, beat_valid, beat_last and beat_data are all zero.
- R2: Before the first sweep_start, accepted samples produce no output, and the history they could have filled is not used.
- R3: After a sweep_start, every DECIM-th in_valid sample (the DECIM-th, 2·DECIM-th, …) produces exactly one beat_valid pulse. The pulse appears in the cycle after that sample's clock edge. No other cycle has beat_valid high.
- R4: An output made at sample index i of the sweep (i counted from 0) equals the sum over k = 0…TAPS-1 of w(k)·p(i-k). Here w(k) = min(k+1, TAPS-k), and p(j) = 0 for j < 0. The sum is held at full precision in a signed accumulator of 2·DW + 2·ceil(log2(TAPS+1)) bits. beat_data is the top OW (default 18) bits of that accumulator, which is an arithmetic right shift.
- R5: p(j) is the signed two's-complement product rx_sample × ref_sample of the same accepted cycle, including the most negative input codes.
- R6: beat_last is high together with the FRAME_LEN-th output of a sweep, and only then. After that output, no further output is produced until the next sweep_start.
- R7: sweep_start restarts the frame even in the middle of a sweep, and it clears the filter history. A sample presented in the same cycle as sweep_start is discarded. The cycle after sweep_start never carries an output.
- R8: Cycles with in_valid low advance neither the decimation phase nor the filter history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sweep_start | input | 1 | Start of a new sweep; opens a frame |
| in_valid | input | 1 | rx_sample and ref_sample are valid |
| rx_sample | input | DW | Received sample, signed |
| ref_sample | input | DW | Reference chirp sample, signed |
| beat_valid | output | 1 | Decimated beat sample valid |
| beat_data | output | OW | Decimated beat sample, signed |
| beat_last | output | 1 | Last sample of the frame |

## Verification
A decimation phase that is off by one moves the first beat_valid pulse of a frame, so the error shows one cycle after the DECIM-th sample. Filter history left over from an earlier sweep or from samples before the first trigger corrupts the first outputs of the next frame. Those outputs depend on zeroed history because TAPS exceeds DECIM in the bench. A wrong frame counter misplaces beat_last at the FRAME_LEN-th output, or lets pulses leak out after it.

// File: rtl/deramp_decim.sv
module deramp_decim #(
  parameter int DW        = 14,
  parameter int TAPS      = 512,
  parameter int DECIM     = 22,
  parameter int FRAME_LEN = 16384,
  parameter int OW        = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sweep_start,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] rx_sample,
  input  logic signed [DW-1:0] ref_sample,
  output logic                 beat_valid,
  output logic signed [OW-1:0] beat_data,
  output logic                 beat_last
);
  localparam int PW   = 2 * DW;
  localparam int CW   = $clog2(TAPS + 1) + 1;
  localparam int ACCW = PW + 2 * $clog2(TAPS + 1);
  localparam int PCW  = $clog2(DECIM);
  localparam int FCW  = $clog2(FRAME_LEN + 1);

  function automatic logic signed [CW-1:0] weight(input int k);
    int up, down;
    up   = k + 1;
    down = TAPS - k;
    return CW'(up < down ? up : down);
  endfunction

  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   hist [1:TAPS-1];
  logic signed [ACCW-1:0] acc;
  logic                   active;
  logic [PCW-1:0]         phase;
  logic [FCW-1:0]         nout;

  assign prod = rx_sample * ref_sample;

  wire take = in_valid && active && !sweep_start;
  wire fire = take && (phase == PCW'(DECIM - 1));

  always_comb begin
    acc = ACCW'(prod);
    for (int k = 1; k < TAPS; k++)
      acc = acc + ACCW'(hist[k]) * ACCW'(weight(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      phase      <= '0;
      nout       <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_data  <= '0;
      for (int k = 1; k < TAPS; k++) hist[k] <= '0;
    end else begin
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      if (sweep_start) begin
        active <= 1'b1;
        phase  <= '0;
        nout   <= '0;
        for (int k = 1; k < TAPS; k++) hist[k] <= '0;
      end else if (take) begin
        hist[1] <= prod;
        for (int k = 2; k < TAPS; k++) hist[k] <= hist[k-1];
        phase <= fire ? '0 : phase + 1'b1;
        if (fire) begin
          beat_valid <= 1'b1;
          beat_data  <= acc[ACCW-1 -: OW];
          nout       <= nout + 1'b1;
          if (nout == FCW'(FRAME_LEN - 1)) begin
            beat_last <= 1'b1;
            active    <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/deramp_decim_chk.sv
module deramp_decim_chk #(
  parameter int DECIM     = 22,
  parameter int FRAME_LEN = 16384
) (
  input logic clk,
  input logic rst_n,
  input logic sweep_start,
  input logic in_valid,
  input logic beat_valid,
  input logic beat_last
);
  logic act;
  int   smp, outs;

  wire due = in_valid && act && !sweep_start && (smp == DECIM - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      smp  <= 0;
      outs <= 0;
    end else if (sweep_start) begin
      act  <= 1'b1;
      smp  <= 0;
      outs <= 0;
    end else if (in_valid && act) begin
      smp <= (smp == DECIM - 1) ? 0 : smp + 1;
      if (smp == DECIM - 1) begin
        outs <= outs + 1;
        if (outs == FRAME_LEN - 1) act <= 1'b0;
      end
    end
  end

  a_r3_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $past(due));
  a_r3_never_missed: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> beat_valid);
  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
  a_r6_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_last == (outs == FRAME_LEN)));
  a_r7_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> !beat_valid);
endmodule

bind deramp_decim deramp_decim_chk #(.DECIM(DECIM), .FRAME_LEN(FRAME_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .in_valid(in_valid),
  .beat_valid(beat_valid), .beat_last(beat_last)
);

// File: tb/test_deramp_decim.sv
`timescale 1ns/1ps
module test_deramp_decim;
  localparam int DW = 14, TAPS = 16, DECIM = 6, NF = 8, OW = 18;
  localparam int ACCW = 2 * DW + 2 * $clog2(TAPS + 1);

  logic clk = 1'b0, rst_n = 1'b0, sweep_start = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] rx_sample = '0, ref_sample = '0;
  logic beat_valid, beat_last;
  logic signed [OW-1:0] beat_data;

  always #4 clk = ~clk;

  deramp_decim #(.DW(DW), .TAPS(TAPS), .DECIM(DECIM), .FRAME_LEN(NF), .OW(OW)) i_deramp_decim (
    .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .in_valid(in_valid),
    .rx_sample(rx_sample), .ref_sample(ref_sample),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last));

  int n_tests = 0, n_fail = 0;
  longint prods [64];
  int cnt = 0, outs = 0;
  bit act = 0, exp_v = 0, exp_l = 0, done = 0;
  logic [OW-1:0] exp_d = '0;
  string tag = "R1";

  function automatic int wt(int k);
    return (k + 1 < TAPS - k) ? k + 1 : TAPS - k;
  endfunction

  function automatic logic [OW-1:0] model_out(int idx);
    longint acc = 0;
    for (int k = 0; k < TAPS; k++)
      if (idx - k >= 0) acc += longint'(wt(k)) * prods[idx-k];
    acc = acc >>> (ACCW - OW);
    return acc[OW-1:0];
  endfunction

  function automatic int rnd_s();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  task automatic check_out();
    n_tests++;
    if (beat_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s beat_valid actual %0b expected %0b", tag, beat_valid, exp_v);
    end
    if (exp_v) begin
      n_tests += 2;
      if (beat_data !== exp_d) begin
        n_fail++;
        $display("FAIL %s beat_data actual %0d expected %0d", tag, beat_data, $signed(exp_d));
      end
      if (beat_last !== exp_l) begin
        n_fail++;
        $display("FAIL %s beat_last actual %0b expected %0b", tag, beat_last, exp_l);
      end
    end
  endtask

  task automatic step(bit st, bit v, int rx, int rf, string t);
    @(negedge clk);
    check_out();
    tag = t;
    sweep_start = st;
    in_valid    = v;
    rx_sample   = DW'(rx);
    ref_sample  = DW'(rf);
    exp_v = 0;
    exp_l = 0;
    if (st) begin
      act = 1; cnt = 0; outs = 0;
    end else if (v && act) begin
      prods[cnt] = longint'(rx) * longint'(rf);
      if ((cnt + 1) % DECIM == 0) begin
        exp_v = 1;
        exp_d = model_out(cnt);
        outs++;
        exp_l = (outs == NF);
        if (exp_l) act = 0;
      end
      cnt++;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    n_tests++;
    if (beat_valid !== 1'b0 || beat_last !== 1'b0 || beat_data !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual %0b/%0b/%0d expected 0/0/0", beat_valid, beat_last, beat_data);
    end
    rst_n = 1'b1;
    // R2: samples before any trigger
    for (int i = 0; i < 10; i++) step(0, 1, rnd_s(), rnd_s(), "R2");
    // R4 and R8: random frame with gaps
    step(1, 0, 0, 0, "R7");
    while (act) begin
      bit v = ($urandom_range(9) < 7);
      step(0, v, rnd_s(), rnd_s(), v ? "R4" : "R8");
    end
    // R6: no output after the frame is complete
    for (int i = 0; i < 15; i++) step(0, 1, rnd_s(), rnd_s(), "R6");
    // R7: restart mid-frame, sample in trigger cycle dropped
    step(1, 0, 0, 0, "R7");
    for (int i = 0; i < 20; i++) step(0, 1, rnd_s(), rnd_s(), "R7");
    step(1, 1, 8191, 8191, "R7");
    while (act) step(0, 1, rnd_s(), rnd_s(), "R7");
    // R5: extreme signed codes
    step(1, 0, 0, 0, "R5");
    while (act) begin
      int a = $urandom_range(1) ? -8192 : 8191;
      int b = $urandom_range(1) ? -8192 : 8191;
      step(0, 1, a, b, "R5");
    end
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");
    done = 1;
    summary();
    $finish;
  end
endmodule